// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral that sits on the byte-wide register bus of a small microcontroller. Software arms it by programming a control register. From then on, software must restart the count before it runs out. If the count does run out, the block issues a one-cycle reset pulse to the rest of the system. It also records in a sticky flag that the watchdog caused the reset.

A key register protects the control register against stray writes. Two specific bytes written in order open it for writing, and two bytes in the reverse order close it again. A free-running prescaler with eight power-of-two ratios paces a counter, and the overflow of that counter is the timeout. A separate configuration register holds the sticky cause flag and an inhibit bit that drives a pin directly.

Registers sit at addresses 0 (key), 1 (control) and 2 (configuration). Address 3 reads as 0x00. Read data is registered: `rdata_o` shows the addressed register one clock after `addr_i` is presented.

Top module: `kwdt_top`

## Requirements
- R1: After the power-on reset `rst`, the key, control and configuration registers all read 0x00, and `wdt_rst_o` and `inhibit_o` are low.
- R2: Two consecutive key-register writes, first 0x1E and then 0xE1, open the control register for writes.
- R3: A control write made while locked changes nothing. The key register always reads 0x00.
- R4: A key write that does not match the next expected byte returns the key logic to the locked state. This applies during the opening pair and also once open (any byte other than 0xE1).
- R5: While open, writing 0xE1 and then 0x1E locks the control register again. Control writes still take effect between those two key bytes.
- R6: Control layout: bit 7 enables the watchdog, bit 5 is the restart bit and bits 2:0 select the prescaler. The other bits read as 0.
- R7: From the clock edge that writes enable=1 with select s, `wdt_rst_o` rises exactly 2^(CNT_W+3+s) cycles later and stays high for one cycle only.
- R8: Writing 1 to bit 5 restarts the count and the bit reads back 0 afterwards. The next timeout comes 2^(CNT_W+3+s)+1 cycles after that write.
- R9: With the enable bit at 0, the count stops and returns to zero, and no pulse occurs. Enabling again gives a full period.
- R10: The timeout pulse clears the control register, the counter and the key logic, so control writes are then ignored until a new unlock.
- R11: Configuration bit 7 is set by a timeout and survives the pulse. Writing 0 to it clears it, writing 1 to it has no effect, and `rst` clears it.
- R12: Configuration bit 0 is read/write, drives `inhibit_o`, and is not changed by the watchdog pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Registered read data |
| wdt_rst_o | output | 1 | One-cycle timeout reset pulse |
| inhibit_o | output | 1 | Copy of configuration bit 0 |

## Verification
The bench builds the block with CNT_W=4 instead of 16. A timeout then takes 128 cycles at the fastest select and 16384 at the slowest, so every prescaler ratio, including the extreme select 7, can be timed to the exact cycle. The short period also lets the bench repeat the full timeout, relock and flag sequence several times with random select values. Key-register handling is driven with random byte streams against a reference model of the lock states.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [DATA_W-1:0] KEY_OPEN_A = 8'h1E;
  localparam logic [DATA_W-1:0] KEY_OPEN_B = 8'hE1;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_CLR_BIT = 5;
  localparam int CFG_FLAG_BIT = 7;
  localparam int CFG_INH_BIT  = 0;

  typedef enum logic [1:0] {
    KEY_LOCKED    = 2'd0,
    KEY_HALF_OPEN = 2'd1,
    KEY_OPEN      = 2'd2,
    KEY_HALF_SHUT = 2'd3
  } key_state_e;
endpackage

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlocked
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      unique case (state_q)
        KEY_LOCKED:    state_d = (key_data == KEY_OPEN_A) ? KEY_HALF_OPEN : KEY_LOCKED;
        KEY_HALF_OPEN: state_d = (key_data == KEY_OPEN_B) ? KEY_OPEN      : KEY_LOCKED;
        KEY_OPEN:      state_d = (key_data == KEY_OPEN_B) ? KEY_HALF_SHUT : KEY_LOCKED;
        KEY_HALF_SHUT: state_d = KEY_LOCKED;
        default:       state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KEY_LOCKED;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == KEY_OPEN) || (state_q == KEY_HALF_SHUT);
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < BASE_LOG2 + int'(sel));
    end
  end

  assign tick = run && (&(div_q | ~mask));

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ovf = run && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               BASE_LOG2 = 3,
  parameter int               ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 2'd0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd1,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o,
  output logic              inhibit_o
);
  logic             wdt_rst_q;
  logic             soft_rst;
  logic             unlocked;
  logic             en_q, clr_q;
  logic [SEL_W-1:0] ps_q;
  logic             flag_q, inh_q;
  logic             run, tick, ovf;
  logic [CNT_W-1:0] cnt;
  logic             key_we, ctrl_we, cfg_we;
  logic             wdata_unused;

  assign soft_rst     = rst || wdt_rst_q;
  assign key_we       = we_i && (addr_i == KEY_ADDR);
  assign ctrl_we      = we_i && (addr_i == CTRL_ADDR) && unlocked;
  assign cfg_we       = we_i && (addr_i == CFG_ADDR);
  assign run          = en_q && !clr_q;
  assign wdata_unused = ^{wdata_i[6], wdata_i[4:3]};

  kwdt_keyfsm u_key (
    .clk      (clk),
    .rst      (soft_rst),
    .key_we   (key_we),
    .key_data (wdata_i),
    .unlocked (unlocked)
  );

  kwdt_prescale #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk  (clk),
    .rst  (soft_rst),
    .run  (run),
    .sel  (ps_q),
    .tick (tick)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (soft_rst),
    .run  (run),
    .tick (tick),
    .ovf  (ovf),
    .cnt  (cnt)
  );

  // control register; restart bit lives one cycle
  always_ff @(posedge clk) begin
    if (soft_rst) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
      ps_q  <= '0;
    end else if (ctrl_we) begin
      en_q  <= wdata_i[CTRL_EN_BIT];
      clr_q <= wdata_i[CTRL_CLR_BIT];
      ps_q  <= wdata_i[SEL_W-1:0];
    end else begin
      clr_q <= 1'b0;
    end
  end

  // configuration register: only power-on reset clears it
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      inh_q  <= 1'b0;
    end else begin
      if (ovf)                                flag_q <= 1'b1;
      else if (cfg_we && !wdata_i[CFG_FLAG_BIT]) flag_q <= 1'b0;
      if (cfg_we) inh_q <= wdata_i[CFG_INH_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wdt_rst_q <= 1'b0;
    else     wdt_rst_q <= ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (addr_i == CTRL_ADDR) begin
        rdata_o[CTRL_EN_BIT]  <= en_q;
        rdata_o[CTRL_CLR_BIT] <= clr_q;
        rdata_o[SEL_W-1:0]    <= ps_q;
      end else if (addr_i == CFG_ADDR) begin
        rdata_o[CFG_FLAG_BIT] <= flag_q;
        rdata_o[CFG_INH_BIT]  <= inh_q;
      end
    end
  end

  assign wdt_rst_o = wdt_rst_q;
  assign inhibit_o = inh_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int               CNT_W     = 16,
  parameter int               ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd1,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 2'd2
) (
  input logic              clk,
  input logic              rst,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wdt_rst_q,
  input logic              unlocked,
  input logic              en_q,
  input logic              clr_q,
  input logic [SEL_W-1:0]  ps_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag_q
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_q |=> !wdt_rst_q);

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == CTRL_ADDR && !unlocked && !wdt_rst_q)
      |=> (en_q == $past(en_q) && ps_q == $past(ps_q)));

  // R8
  clr_self_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_q && !(we_i && addr_i == CTRL_ADDR && unlocked)) |=> !clr_q);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (cnt == '0));

  // R10
  pulse_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_q |=> (!en_q && !unlocked && cnt == '0));

  // R11
  flag_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_q |-> flag_q);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(we_i && addr_i == CFG_ADDR && !wdata_i[CFG_FLAG_BIT])) |=> flag_q);
endmodule

bind kwdt_top kwdt_chk #(
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .CFG_ADDR  (CFG_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wdt_rst_q (wdt_rst_q),
  .unlocked  (unlocked),
  .en_q      (en_q),
  .clr_q     (clr_q),
  .ps_q      (ps_q),
  .cnt       (cnt),
  .flag_q    (flag_q)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
  localparam int TB_CNT_W = 4;
  localparam logic [1:0] A_KEY = 2'd0, A_CTRL = 2'd1, A_CFG = 2'd2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       wdt_rst;
  logic       inhibit;

  int checks = 0;
  int failures = 0;

  kwdt_top #(.CNT_W(TB_CNT_W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .rdata_o   (rdata),
    .wdt_rst_o (wdt_rst),
    .inhibit_o (inhibit)
  );

  always #5 clk = ~clk;

  function automatic int period(input int ps);
    return 1 << (TB_CNT_W + 3 + ps);
  endfunction

  // model of the key lock states: 0 locked,1 half open,2 open,3 half shut
  function automatic int key_next(input int s, input logic [7:0] b);
    case (s)
      0: return (b == 8'h1E) ? 1 : 0;
      1: return (b == 8'hE1) ? 2 : 0;
      2: return (b == 8'hE1) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic unlock();
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1);
  endtask

  // cycles from the last write edge until the pulse is seen
  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (wdt_rst) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    int ks;
    logic [7:0] ctrl_m;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(A_KEY, v);  chk("R1 key", v, 8'h00);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_CFG, v);  chk("R1 cfg", v, 8'h00);
    chk("R1 pulse low", wdt_rst, 0);
    chk("R1 inhibit low", inhibit, 0);

    // R3 locked write ignored, key reads zero
    wr(A_CTRL, 8'h87);
    rd(A_CTRL, v); chk("R3 locked ctrl", v, 8'h00);
    wr(A_KEY, 8'h1E);
    rd(A_KEY, v);  chk("R3 key reads zero", v, 8'h00);

    // R4 broken opening sequences
    wr(A_KEY, 8'h55); wr(A_KEY, 8'hE1);
    wr(A_CTRL, 8'h07);
    rd(A_CTRL, v); chk("R4 broken 1E,55,E1", v, 8'h00);
    wr(A_KEY, 8'h1E); wr(A_KEY, 8'h1E); wr(A_KEY, 8'hE1);
    wr(A_CTRL, 8'h07);
    rd(A_CTRL, v); chk("R4 broken 1E,1E,E1", v, 8'h00);

    // R2 / R6 unlock and layout
    unlock();
    wr(A_CTRL, 8'h07);
    rd(A_CTRL, v); chk("R2 unlocked write", v, 8'h07);
    wr(A_CTRL, 8'h7E);
    rd(A_CTRL, v); chk("R6 unused bits zero", v, 8'h06);
    wr(A_CTRL, 8'h00);

    // R7 fastest select, exact timing
    wr(A_CTRL, 8'h80);
    wait_pulse(4 * period(0), n);
    chk("R7 period sel0", n, period(0));
    @(negedge clk);
    chk("R7 pulse one cycle", wdt_rst, 0);
    rd(A_CTRL, v); chk("R10 ctrl cleared", v, 8'h00);
    rd(A_CFG, v);  chk("R11 flag set", v, 8'h80);
    wr(A_CTRL, 8'h81);
    rd(A_CTRL, v); chk("R10 relocked", v, 8'h00);

    // R11 / R12 configuration register
    wr(A_CFG, 8'h81);
    rd(A_CFG, v); chk("R11 write 1 no effect", v, 8'h81);
    chk("R12 inhibit out", inhibit, 1);
    wr(A_CFG, 8'h01);
    rd(A_CFG, v); chk("R11 flag cleared", v, 8'h01);

    // R7 random selects, R12 inhibit kept across pulse
    for (int t = 0; t < 3; t++) begin
      int ps;
      ps = $urandom_range(1, 4);
      unlock();
      wr(A_CTRL, 8'h80 | 8'(ps));
      wait_pulse(4 * period(ps), n);
      chk("R7 period random sel", n, period(ps));
      chk("R12 inhibit kept", inhibit, 1);
    end

    // R7 slowest select
    unlock();
    wr(A_CTRL, 8'h87);
    wait_pulse(2 * period(7), n);
    chk("R7 period sel7", n, period(7));

    // R8 restart bit
    unlock();
    wr(A_CTRL, 8'h81);
    repeat (200) @(negedge clk);
    wr(A_CTRL, 8'hA1);
    wait_pulse(4 * period(1), n);
    chk("R8 restart timing", n, period(1) + 1);
    unlock();
    wr(A_CTRL, 8'hA0);
    rd(A_CTRL, v); chk("R8 bit self clears", v, 8'h80);

    // R9 disable
    wr(A_CTRL, 8'h00);
    wait_pulse(3000, n);
    chk("R9 no pulse when off", wdt_rst, 0);
    wr(A_CTRL, 8'h80);
    wait_pulse(4 * period(0), n);
    chk("R9 full period after re-enable", n, period(0));

    // R5 lock sequence
    unlock();
    wr(A_KEY, 8'hE1);
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, v); chk("R5 writable mid-lock", v, 8'h03);
    wr(A_KEY, 8'h1E);
    wr(A_CTRL, 8'h05);
    rd(A_CTRL, v); chk("R5 locked again", v, 8'h03);

    // R4 wrong byte while open
    unlock();
    wr(A_KEY, 8'h33);
    wr(A_CTRL, 8'h06);
    rd(A_CTRL, v); chk("R4 wrong byte while open", v, 8'h03);

    // R4 random key streams against the model
    ks = 0;
    ctrl_m = 8'h03;
    for (int t = 0; t < 10; t++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] b;
        case ($urandom_range(0, 2))
          0: b = 8'h1E;
          1: b = 8'hE1;
          default: b = 8'($urandom);
        endcase
        wr(A_KEY, b);
        ks = key_next(ks, b);
      end
      v = 8'($urandom) & 8'h07;
      wr(A_CTRL, v);
      if (ks >= 2) ctrl_m = v;
      rd(A_CTRL, v); chk("R4 random key stream", v, ctrl_m);
    end

    // R1 / R11 power-on reset clears flag and inhibit
    wr(A_CTRL, 8'h00);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(A_CFG, v); chk("R11 reset clears cfg", v, 8'h00);
    chk("R1 inhibit after reset", inhibit, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule